// File: doc/BRIEF.md
# Battery Charge Sequencing Controller

This block is the digital sequencer of a single-cell lithium charger. It runs on the system clock and turns a set of comparator flags (input power good, enable, battery above the fast-charge minimum, battery at the final voltage, battery above the recharge level and charge current below the end-of-charge level) into a charge mode, a current-reference select and an open-drain status request. Every flag and the slow timing oscillator pass through two-flop synchronizers. A rising edge of the synchronized oscillator makes a tick that is one clock wide, and both qualification counters advance on that tick.

The states are OFF, TRICKLE, CC, CV and DONE. The transitions are:

- OFF to TRICKLE when power and enable are both present.
- TRICKLE to CC after `QUAL_TICKS` consecutive ticks with the minimum flag true.
- CC to CV when the final-voltage flag is set.
- CV to DONE when the current is low, the recharge level has been exceeded and the `BLANK_TICKS` blanking window has expired.
- DONE to TRICKLE when the battery falls below the recharge level.
- Any state to OFF when power or enable is lost.

In DONE the charger keeps regulating in constant-voltage mode and releases the status line.

Top module: `chg_seq_ctrl`

## Requirements
- R1: While reset is held, or while power-good is low, `mode_o` is 0 (off), `iref_tenth_o` is 0 and `status_pull_o` is 0 (line released).
- R2: When power and enable are both present, the controller starts a cycle in trickle: `mode_o` = 1, `iref_tenth_o` = 1 (one tenth of the programmed current) and `status_pull_o` = 1 (line pulled low).
- R3: Trickle ends only after the synchronized minimum flag has been true for 15 ticks in a row. After 14 ticks the mode is still 1; after 15 ticks it is 2 (constant current, `iref_tenth_o` = 0).
- R4: If the minimum flag drops during qualification, the tick count restarts from zero and the controller stays in trickle.
- R5: In constant current, a true final-voltage flag moves the mode to 3 (constant voltage). `iref_tenth_o` stays 0.
- R6: End-of-charge requires three things: the low-current flag, the recharge-level flag, and 16 ticks counted since the recharge-level flag last rose. When it is recognized, `status_pull_o` becomes 0.
- R7: After end-of-charge the status stays released even if the low-current flag clears, and `mode_o` stays 3 (charging continues).
- R8: In the done state, a battery below the recharge level starts a new cycle: `mode_o` = 1 and `status_pull_o` = 1.
- R9: A low enable forces mode 0 with the status released. When enable returns, a fresh trickle cycle begins.
- R10: A low-current flag while the battery is below the recharge level never produces end-of-charge; the status stays pulled low in mode 3.
- R11: Losing power clears the qualification progress. After power returns, a full 15 new ticks are needed to leave trickle.
- R12: Each rising edge of the oscillator input counts as exactly one tick, however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_i | input | 1 | Slow timing oscillator, asynchronous |
| pwr_ok_i | input | 1 | Input power above power-on threshold |
| en_i | input | 1 | Charger enable (floating pin reads as 1) |
| bat_min_i | input | 1 | Battery above fast-charge minimum |
| bat_full_i | input | 1 | Battery at final charge voltage |
| bat_rchg_i | input | 1 | Battery above recharge threshold |
| i_low_i | input | 1 | Charge current below end-of-charge level |
| mode_o | output | 2 | 0 off, 1 trickle, 2 constant current, 3 constant voltage |
| iref_tenth_o | output | 1 | 1 selects one tenth of the programmed current |
| status_pull_o | output | 1 | 1 pulls the open-drain status low, 0 releases it |

## Verification
Two functions can land on the same tick: the expiry of the blanking window and a low-current flag that is already present. To provoke this, the bench raises the recharge flag and the low-current flag together in constant-voltage mode and then sweeps the number of ticks from 0 to 17. It expects the status to be released from tick 16 onward and not one tick sooner. A second overlap is a recharge-level drop while the low-current flag is true. The bench judges this case by keeping the recharge flag low for many ticks and requiring the status to stay pulled low.

// File: rtl/chg_pkg.sv
package chg_pkg;
    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_TRICKLE = 2'd1,
        MODE_CC      = 2'd2,
        MODE_CV      = 2'd3
    } mode_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_TRICKLE,
        ST_CC,
        ST_CV,
        ST_DONE
    } chg_state_t;

    localparam int unsigned N_FLAGS = 7;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/chg_tick_gen.sv
module chg_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_s,
    output logic tick_o
);
    logic osc_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) osc_prev <= 1'b0;
        else        osc_prev <= osc_s;
    end

    assign tick_o = osc_s & ~osc_prev;
endmodule

// File: rtl/chg_tick_counter.sv
module chg_tick_counter #(
    parameter int unsigned LIMIT = 15,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    output logic          done_o,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        count_o <= '0;
        else if (clr_i)                    count_o <= '0;
        else if (tick_i && count_o != LIM) count_o <= count_o + 1'b1;
    end

    assign done_o = (count_o == LIM);
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_TICKS  = 15,
    parameter int unsigned BLANK_TICKS = 16,
    localparam int unsigned QW = $clog2(QUAL_TICKS + 1),
    localparam int unsigned BW = $clog2(BLANK_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_i,
    input  logic       pwr_ok_i,
    input  logic       en_i,
    input  logic       bat_min_i,
    input  logic       bat_full_i,
    input  logic       bat_rchg_i,
    input  logic       i_low_i,
    output logic [1:0] mode_o,
    output logic       iref_tenth_o,
    output logic       status_pull_o
);
    import chg_pkg::*;

    logic [N_FLAGS-1:0] raw_flags, syn_flags;
    logic osc_s, pwr_s, en_s, min_s, full_s, rchg_s, ilow_s;
    logic tick;
    logic qual_clr, qual_done, blank_clr, blank_done;
    logic [QW-1:0] qual_cnt;
    logic [BW-1:0] blank_cnt;
    chg_state_t state, state_nx;
    mode_t      mode;

    assign raw_flags = {osc_i, pwr_ok_i, en_i, bat_min_i, bat_full_i, bat_rchg_i, i_low_i};
    assign {osc_s, pwr_s, en_s, min_s, full_s, rchg_s, ilow_s} = syn_flags;

    chg_sync #(.WIDTH(N_FLAGS), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_flags), .q_o(syn_flags)
    );

    chg_tick_gen i_tick (
        .clk(clk), .rst_n(rst_n), .osc_s(osc_s), .tick_o(tick)
    );

    // Qualification of the minimum flag, only while trickling
    assign qual_clr = (state != ST_TRICKLE) || !min_s;

    chg_tick_counter #(.LIMIT(QUAL_TICKS)) i_qual (
        .clk(clk), .rst_n(rst_n), .clr_i(qual_clr), .tick_i(tick),
        .done_o(qual_done), .count_o(qual_cnt)
    );

    // Blanking window that starts when the recharge level is exceeded
    assign blank_clr = !rchg_s || (state == ST_OFF);

    chg_tick_counter #(.LIMIT(BLANK_TICKS)) i_blank (
        .clk(clk), .rst_n(rst_n), .clr_i(blank_clr), .tick_i(tick),
        .done_o(blank_done), .count_o(blank_cnt)
    );

    always_comb begin
        state_nx = state;
        if (!pwr_s || !en_s) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     state_nx = ST_TRICKLE;
                ST_TRICKLE: if (qual_done) state_nx = ST_CC;
                ST_CC:      if (full_s) state_nx = ST_CV;
                ST_CV:      if (ilow_s && rchg_s && blank_done) state_nx = ST_DONE;
                ST_DONE:    if (!rchg_s) state_nx = ST_TRICKLE;
                default:    state_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        mode          = MODE_OFF;
        iref_tenth_o  = 1'b0;
        status_pull_o = 1'b0;
        unique case (state)
            ST_OFF: begin
                mode = MODE_OFF;
            end
            ST_TRICKLE: begin
                mode          = MODE_TRICKLE;
                iref_tenth_o  = 1'b1;
                status_pull_o = 1'b1;
            end
            ST_CC: begin
                mode          = MODE_CC;
                status_pull_o = 1'b1;
            end
            ST_CV: begin
                mode          = MODE_CV;
                status_pull_o = 1'b1;
            end
            ST_DONE: begin
                mode = MODE_CV;
            end
            default: mode = MODE_OFF;
        endcase
    end

    assign mode_o = mode;
endmodule

// File: rtl/chg_seq_checker.sv
module chg_seq_checker #(
    parameter int unsigned QW = 4,
    parameter int unsigned BW = 5,
    parameter int unsigned QUAL_TICKS  = 15,
    parameter int unsigned BLANK_TICKS = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_o,
    input logic          status_pull_o,
    input logic          iref_tenth_o,
    input logic          en_s,
    input logic          pwr_s,
    input logic          rchg_s,
    input logic          ilow_s,
    input logic          qual_done,
    input logic          blank_done,
    input logic [QW-1:0] qual_cnt,
    input logic [BW-1:0] blank_cnt
);
    a_r1_off_releases_status: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> (!status_pull_o && !iref_tenth_o));

    a_r2_trickle_pulls_status: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> status_pull_o);

    a_r3_cc_after_qual: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && $past(mode_o) == 2'd1) |-> $past(qual_done));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_cnt <= QW'(QUAL_TICKS)) && (blank_cnt <= BW'(BLANK_TICKS)));

    a_r5_cv_from_cc: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3 && $past(mode_o) != 2'd3) |-> ($past(mode_o) == 2'd2));

    a_r6_eoc_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3 && $fell(status_pull_o)) |->
        ($past(ilow_s) && $past(rchg_s) && $past(blank_done)));

    a_r9_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (mode_o == 2'd0));

    a_r11_power_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |=> (mode_o == 2'd0));
endmodule

bind chg_seq_ctrl chg_seq_checker #(
    .QW(QW), .BW(BW), .QUAL_TICKS(QUAL_TICKS), .BLANK_TICKS(BLANK_TICKS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .status_pull_o(status_pull_o),
    .iref_tenth_o(iref_tenth_o), .en_s(en_s), .pwr_s(pwr_s), .rchg_s(rchg_s),
    .ilow_s(ilow_s), .qual_done(qual_done), .blank_done(blank_done),
    .qual_cnt(qual_cnt), .blank_cnt(blank_cnt)
);

// File: tb/test_chg_seq_ctrl.sv
module test_chg_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL  = 15;
    localparam int BLANK = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc = 1'b0, pwr = 1'b0, en = 1'b1, bmin = 1'b0, bfull = 1'b0, brchg = 1'b0, ilow = 1'b0;
    logic [1:0] mode;
    logic tenth, spull;
    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_seq_ctrl i_chg_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .osc_i(osc), .pwr_ok_i(pwr), .en_i(en),
        .bat_min_i(bmin), .bat_full_i(bfull), .bat_rchg_i(brchg), .i_low_i(ilow),
        .mode_o(mode), .iref_tenth_o(tenth), .status_pull_o(spull)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n = 6);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int high_cycles = 4);
        osc = 1'b1;
        settle(high_cycles);
        osc = 1'b0;
        settle(4);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic restart();
        en = 1'b0; settle();
        en = 1'b1; settle();
    endtask

    task automatic to_cv();
        bfull = 1'b0; brchg = 1'b0; ilow = 1'b0; bmin = 1'b1;
        restart();
        ticks(QUAL);
        bfull = 1'b1; settle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        settle(3);
        chk("R1 reset mode", mode, 0);
        chk("R1 reset status", spull, 0);
        rst_n = 1'b1; settle();
        chk("R1 no power mode", mode, 0);
        chk("R1 no power tenth", tenth, 0);

        pwr = 1'b1; settle();
        chk("R2 trickle mode", mode, 1);
        chk("R2 trickle tenth", tenth, 1);
        chk("R2 trickle status", spull, 1);

        // R3 sweep of tick counts
        for (int n = 0; n <= QUAL + 1; n++) begin
            bmin = 1'b1; restart();
            ticks(n);
            chk($sformatf("R3 mode after %0d ticks", n), mode, (n >= QUAL) ? 2 : 1);
            chk($sformatf("R3 tenth after %0d ticks", n), tenth, (n >= QUAL) ? 0 : 1);
        end

        // R4 dropout at each position
        for (int k = 1; k < QUAL; k++) begin
            bmin = 1'b1; restart();
            ticks(k);
            bmin = 1'b0; tick(); bmin = 1'b1; settle();
            ticks(QUAL - 1);
            chk($sformatf("R4 dropout at %0d held", k), mode, 1);
            tick();
            chk($sformatf("R4 dropout at %0d then qualified", k), mode, 2);
        end

        // R12 long-high oscillator counts once
        bmin = 1'b1; restart();
        ticks(QUAL - 2);
        tick(30);
        chk("R12 long pulse is one tick", mode, 1);
        tick();
        chk("R12 next edge qualifies", mode, 2);

        // R5
        bfull = 1'b1; settle();
        chk("R5 cv mode", mode, 3);
        chk("R5 full current", tenth, 0);
        chk("R5 status low", spull, 1);

        // R6 blanking sweep
        for (int m = 0; m <= BLANK + 1; m++) begin
            to_cv();
            brchg = 1'b1; ilow = 1'b1; settle();
            ticks(m);
            chk($sformatf("R6 status after %0d ticks", m), spull, (m >= BLANK) ? 0 : 1);
            chk($sformatf("R6 mode after %0d ticks", m), mode, 3);
        end

        // R7 latch, charging continues
        ilow = 1'b0; settle(); ticks(3);
        chk("R7 status latched", spull, 0);
        chk("R7 still cv", mode, 3);

        // R8 recharge
        brchg = 1'b0; settle();
        chk("R8 new cycle mode", mode, 1);
        chk("R8 status low", spull, 1);

        // R10 low current below recharge level
        to_cv();
        ilow = 1'b1; brchg = 1'b0; settle();
        ticks(BLANK + 4);
        chk("R10 no eoc status", spull, 1);
        chk("R10 mode", mode, 3);

        // R9 enable
        brchg = 1'b1; ticks(BLANK + 1);
        chk("R9 reached eoc", spull, 0);
        en = 1'b0; settle();
        chk("R9 disabled mode", mode, 0);
        chk("R9 disabled status", spull, 0);
        en = 1'b1; settle();
        chk("R9 re-enabled mode", mode, 1);
        chk("R9 re-enabled status", spull, 1);

        // R11 power cycle clears qualification
        brchg = 1'b0; ilow = 1'b0; bfull = 1'b0; bmin = 1'b1; restart();
        ticks(10);
        pwr = 1'b0; settle();
        chk("R11 power lost mode", mode, 0);
        chk("R1 power lost status", spull, 0);
        pwr = 1'b1; settle();
        ticks(QUAL - 1);
        chk("R11 partial count cleared", mode, 1);
        tick();
        chk("R11 qualified after full count", mode, 2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule